// File: doc/BRIEF.md
# Machine-Mode Control/Status Register Unit

This block is the control and status register file of a 32-bit core that runs only in machine mode. The execute stage hands it one decoded CSR instruction at a time: the 12-bit CSR number, the 3-bit operation code from the instruction, the value of the first source register and the raw 5-bit source-register field. The block returns the old register value, which the core writes to the destination register. In the same cycle it applies the requested write, set or clear.

It holds eight writable machine registers. It also answers reads of two fixed identification words and of a free-running cycle counter, none of which can be written. Any CSR number not in the map reads as zero, and writes to it are dropped without raising a trap.

Requests arrive on a valid/ready channel and results leave on a second one. The response channel has a single output register. A request is taken only when that register is empty or is being drained in the same cycle, so `req_ready = !rsp_valid || rsp_ready`. While the consumer holds `rsp_ready` low, the pending result stays stable and no new request is accepted. A request's register update takes effect at the clock edge that accepts it.

Top module: `csr_unit`

## Requirements
- R1: After reset every writable register reads zero, `rsp_valid` is low and `req_ready` is high.
- R2: Writable registers respond at these numbers: 0x300 status, 0x304 interrupt enable, 0x305 trap vector, 0x340 scratch, 0x341 exception PC, 0x342 cause, 0x343 trap value, 0x344 interrupt pending. Each holds its own 32-bit value.
- R3: 0xF11 reads 0xFF0FF0FF and 0x301 reads 0x40401101. Writes to either have no effect.
- R4: 0xC00 reads a counter that is CYCLE_W bits wide, zero-extended to 32 bits. The counter is 0 in reset, rises by one on every clock edge out of reset and wraps modulo 2^CYCLE_W. Writes to it are ignored. The value returned is the count just before the accepting edge.
- R5: The operation code selects the action. 1 writes the rs1 value. 2 ORs the rs1 value into the old value. 3 clears from the old value the bits that are set in the rs1 value.
- R6: Operation codes 5, 6 and 7 act like 1, 2 and 3, but their operand is the 5-bit rs1 field, zero-extended. The rs1 value is then ignored.
- R7: The response data is always the register's value before the request's own update.
- R8: An unmapped CSR number reads zero, and a write to it changes no register.
- R9: Operation codes 0 and 4 return the old value and write nothing.
- R10: A request is accepted when `req_valid && req_ready`, and its result is presented with `rsp_valid` high from the next cycle on. `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid && !rsp_ready`, `rsp_rdata` holds and `rsp_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_csr | input | 12 | CSR number |
| req_op | input | 3 | Operation code (funct3) |
| req_rs1_val | input | XLEN | Source register value |
| req_rs1_idx | input | 5 | Source register field, the immediate operand for codes 5 to 7 |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_rdata | output | XLEN | Old CSR value for the destination register |

## Verification
The bench builds the unit with XLEN at 32 and CYCLE_W reduced to 8. This lets the cycle counter wrap several times within a short run, so the modulo behaviour of R4 is checked on real reads taken on both sides of a wrap. The identification words and the register width are left at their defaults, so the fixed values in R3 are compared exactly. In the second half of the run the consumer stalls at pseudo-random times, so results wait in the output register while requests are held off.

// File: rtl/csr_pkg.sv
package csr_pkg;

  localparam int NUM_RW = 8;
  localparam int IDX_W  = $clog2(NUM_RW);

  // CSR numbers of the writable set
  localparam logic [11:0] A_STATUS  = 12'h300;
  localparam logic [11:0] A_IE      = 12'h304;
  localparam logic [11:0] A_TVEC    = 12'h305;
  localparam logic [11:0] A_SCRATCH = 12'h340;
  localparam logic [11:0] A_EPC     = 12'h341;
  localparam logic [11:0] A_CAUSE   = 12'h342;
  localparam logic [11:0] A_TVAL    = 12'h343;
  localparam logic [11:0] A_IP      = 12'h344;
  // read-only numbers
  localparam logic [11:0] A_ISA     = 12'h301;
  localparam logic [11:0] A_VENDOR  = 12'hF11;
  localparam logic [11:0] A_CYCLE   = 12'hC00;

  typedef enum logic [1:0] {
    RO_NONE   = 2'd0,
    RO_VENDOR = 2'd1,
    RO_ISA    = 2'd2,
    RO_CYCLE  = 2'd3
  } ro_sel_e;

  typedef enum logic [1:0] {
    ACT_KEEP  = 2'd0,
    ACT_WRITE = 2'd1,
    ACT_SET   = 2'd2,
    ACT_CLEAR = 2'd3
  } rmw_act_e;

endpackage

// File: rtl/csr_decode.sv
module csr_decode
  import csr_pkg::*;
(
  input  logic [11:0]      addr,
  output logic             rw_hit,
  output logic [IDX_W-1:0] rw_idx,
  output ro_sel_e          ro_sel
);

  always_comb begin
    rw_hit = 1'b1;
    rw_idx = '0;
    ro_sel = RO_NONE;
    unique case (addr)
      A_STATUS:  rw_idx = IDX_W'(0);
      A_IE:      rw_idx = IDX_W'(1);
      A_TVEC:    rw_idx = IDX_W'(2);
      A_SCRATCH: rw_idx = IDX_W'(3);
      A_EPC:     rw_idx = IDX_W'(4);
      A_CAUSE:   rw_idx = IDX_W'(5);
      A_TVAL:    rw_idx = IDX_W'(6);
      A_IP:      rw_idx = IDX_W'(7);
      A_VENDOR:  begin rw_hit = 1'b0; ro_sel = RO_VENDOR; end
      A_ISA:     begin rw_hit = 1'b0; ro_sel = RO_ISA;    end
      A_CYCLE:   begin rw_hit = 1'b0; ro_sel = RO_CYCLE;  end
      default:   rw_hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/csr_rmw.sv
module csr_rmw
  import csr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] old_val,
  input  logic [2:0]      op,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [4:0]      rs1_idx,
  output logic            wr_req,
  output logic [XLEN-1:0] new_val
);

  localparam int PAD_W = XLEN - 5;

  logic [XLEN-1:0] operand;
  rmw_act_e        act;

  // bit 2 of the code picks the immediate operand, bits 1:0 the action
  assign operand = op[2] ? {{PAD_W{1'b0}}, rs1_idx} : rs1_val;
  assign act     = rmw_act_e'(op[1:0]);
  assign wr_req  = (act != ACT_KEEP);

  always_comb begin
    unique case (act)
      ACT_WRITE: new_val = operand;
      ACT_SET:   new_val = old_val | operand;
      ACT_CLEAR: new_val = old_val & ~operand;
      default:   new_val = old_val;
    endcase
  end

endmodule

// File: rtl/csr_store.sv
module csr_store #(
  parameter int XLEN = 32,
  parameter int N    = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N-1:0]           wr_en,
  input  logic [XLEN-1:0]        wr_data,
  output logic [N-1:0][XLEN-1:0] q
);

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)           q[i] <= '0;
      else if (wr_en[i]) q[i] <= wr_data;
    end

    // R5: a register whose enable is low keeps its value
    a_r5_hold_unselected: assert property (@(posedge clk) disable iff (rst)
      !wr_en[i] |=> $stable(q[i]));
  end

  // R2: one request targets at most one register
  a_r2_single_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en));

endmodule

// File: rtl/csr_cycle.sv
module csr_cycle #(
  parameter int CYCLE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  output logic [CYCLE_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + 1'b1;
  end

  // R4: one step per clock, wrapping at the counter width
  a_r4_step: assert property (@(posedge clk) disable iff (rst)
    !rst |=> count == CYCLE_W'($past(count) + 1'b1));

endmodule

// File: rtl/csr_unit.sv
module csr_unit
  import csr_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          CYCLE_W   = 32,
  parameter logic [31:0] VENDOR_ID = 32'hFF0F_F0FF,
  parameter logic [31:0] ISA_WORD  = 32'h4040_1101
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [11:0]     req_csr,
  input  logic [2:0]      req_op,
  input  logic [XLEN-1:0] req_rs1_val,
  input  logic [4:0]      req_rs1_idx,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [XLEN-1:0] rsp_rdata
);

  localparam int CPAD_W = XLEN - CYCLE_W;

  logic                      fire;
  logic                      rw_hit;
  logic [IDX_W-1:0]          rw_idx;
  ro_sel_e                   ro_sel;
  logic [NUM_RW-1:0][XLEN-1:0] regs;
  logic [CYCLE_W-1:0]        cyc;
  logic [XLEN-1:0]           old_val;
  logic [XLEN-1:0]           new_val;
  logic                      wr_req;
  logic [NUM_RW-1:0]         wr_en;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  csr_decode u_dec (
    .addr   (req_csr),
    .rw_hit (rw_hit),
    .rw_idx (rw_idx),
    .ro_sel (ro_sel)
  );

  csr_cycle #(.CYCLE_W(CYCLE_W)) u_cyc (
    .clk   (clk),
    .rst   (rst),
    .count (cyc)
  );

  always_comb begin
    if (rw_hit) old_val = regs[rw_idx];
    else begin
      unique case (ro_sel)
        RO_VENDOR: old_val = XLEN'(VENDOR_ID);
        RO_ISA:    old_val = XLEN'(ISA_WORD);
        RO_CYCLE:  old_val = {{CPAD_W{1'b0}}, cyc};
        default:   old_val = '0;
      endcase
    end
  end

  csr_rmw #(.XLEN(XLEN)) u_rmw (
    .old_val (old_val),
    .op      (req_op),
    .rs1_val (req_rs1_val),
    .rs1_idx (req_rs1_idx),
    .wr_req  (wr_req),
    .new_val (new_val)
  );

  always_comb begin
    wr_en = '0;
    if (fire && rw_hit && wr_req) wr_en[rw_idx] = 1'b1;
  end

  csr_store #(.XLEN(XLEN), .N(NUM_RW)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (new_val),
    .q       (regs)
  );

  // single output register
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= old_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R10: an accepted request shows up as a result in the next cycle
  a_r10_accept: assert property (@(posedge clk) disable iff (rst)
    fire |=> rsp_valid);

  // R10: a stalled result is held unchanged
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  // R8: an unmapped or read-only number never alters the writable set
  a_r8_no_write: assert property (@(posedge clk) disable iff (rst)
    fire && !rw_hit |=> $stable(regs));

  // R9: codes 0 and 4 leave the writable set alone
  a_r9_keep: assert property (@(posedge clk) disable iff (rst)
    fire && (req_op[1:0] == 2'b00) |=> $stable(regs));

endmodule

// File: tb/sim_csr_unit.sv
`timescale 1ns/1ps
module sim_csr_unit;

  localparam int XLEN = 32;
  localparam int CW   = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [11:0]     req_csr = '0;
  logic [2:0]      req_op = '0;
  logic [XLEN-1:0] req_rs1_val = '0;
  logic [4:0]      req_rs1_idx = '0;
  logic            rsp_valid;
  logic            rsp_ready = 1'b1;
  logic [XLEN-1:0] rsp_rdata;

  always #4 clk = ~clk;

  csr_unit #(.XLEN(XLEN), .CYCLE_W(CW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_csr(req_csr), .req_op(req_op), .req_rs1_val(req_rs1_val),
    .req_rs1_idx(req_rs1_idx), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;
  bit stall_en = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] tb_cyc = '0;
  logic [31:0] model [8];
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          stalled_prev = 0;
  logic [31:0] stall_data = '0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic int slot(logic [11:0] a);
    case (a)
      12'h300: return 0; 12'h304: return 1; 12'h305: return 2; 12'h340: return 3;
      12'h341: return 4; 12'h342: return 5; 12'h343: return 6; 12'h344: return 7;
      default: return -1;
    endcase
  endfunction

  // bench cycle count, same reset and step rule as R4
  always @(posedge clk) begin
    if (rst) tb_cyc <= '0;
    else     tb_cyc <= tb_cyc + 1;
  end

  // consumer: ready changes just after the edge
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rsp_ready <= !stall_en || lfsr[0] || lfsr[3];
  end

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (stalled_prev) begin
        check("R10 held valid", {31'd0, rsp_valid}, 32'd1);
        check("R10 held data", rsp_rdata, stall_data);
      end
      check("R10 ready rule", {31'd0, req_ready}, {31'd0, !rsp_valid || rsp_ready});
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) check("R10 unexpected result", rsp_rdata, 32'hDEAD_BEEF);
        else begin
          automatic logic [31:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(t, rsp_rdata, e);
        end
      end
      stalled_prev = rsp_valid && !rsp_ready;
      stall_data   = rsp_rdata;
    end
  end

  // driver: predicts the result, pushes it, then presents the request
  task automatic issue(string tag, logic [11:0] a, logic [2:0] op,
                       logic [31:0] v, logic [4:0] f);
    logic [31:0] old, opnd, nv;
    int s;
    @(negedge clk);
    req_valid = 1'b1; req_csr = a; req_op = op; req_rs1_val = v; req_rs1_idx = f;
    while (!req_ready) @(negedge clk);
    s = slot(a);
    if (s >= 0)            old = model[s];
    else if (a == 12'hF11) old = 32'hFF0F_F0FF;
    else if (a == 12'h301) old = 32'h4040_1101;
    else if (a == 12'hC00) old = {24'd0, tb_cyc[7:0]};
    else                   old = 32'd0;
    exp_q.push_back(old);
    tag_q.push_back(tag);
    opnd = op[2] ? {27'd0, f} : v;
    case (op[1:0])
      2'd1: nv = opnd;
      2'd2: nv = old | opnd;
      2'd3: nv = old & ~opnd;
      default: nv = old;
    endcase
    if (s >= 0) model[s] = nv;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  localparam logic [11:0] RW_LIST [8] = '{12'h300, 12'h304, 12'h305, 12'h340,
                                          12'h341, 12'h342, 12'h343, 12'h344};

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    check("R1 req_ready after reset", {31'd0, req_ready}, 32'd1);
    for (int i = 0; i < 8; i++) issue("R1 reset value", RW_LIST[i], 3'd2, 32'd0, 5'd0);
    // R2/R5/R7: distinct writes, each returning the old value
    for (int i = 0; i < 8; i++)
      issue("R5 write old", RW_LIST[i], 3'd1, 32'h1111_0000 * (i + 1) + i, 5'd3);
    for (int i = 0; i < 8; i++) issue("R2 readback", RW_LIST[i], 3'd2, 32'd0, 5'd0);
    issue("R5 set", 12'h340, 3'd2, 32'hF000_000F, 5'd0);
    issue("R5 clear", 12'h340, 3'd3, 32'h0FF0_0FF0, 5'd0);
    issue("R7 after clear", 12'h340, 3'd1, 32'hA5A5_5A5A, 5'd0);
    issue("R5 value", 12'h340, 3'd2, 32'd0, 5'd0);
    // R6: immediate forms ignore the rs1 value
    issue("R6 write imm", 12'h341, 3'd5, 32'hFFFF_FFFF, 5'd31);
    issue("R6 check", 12'h341, 3'd6, 32'hFFFF_FFFF, 5'd0);
    issue("R6 set imm", 12'h341, 3'd6, 32'h8000_0000, 5'd8);
    issue("R6 clear imm", 12'h341, 3'd7, 32'hFFFF_FFFF, 5'd5);
    issue("R6 result", 12'h341, 3'd2, 32'd0, 5'd0);
    // R9: codes 0 and 4
    issue("R9 code0", 12'h342, 3'd0, 32'hFFFF_FFFF, 5'd31);
    issue("R9 code4", 12'h342, 3'd4, 32'h0, 5'd31);
    issue("R9 unchanged", 12'h342, 3'd2, 32'd0, 5'd0);
    // R3: identification words
    issue("R3 vendor", 12'hF11, 3'd1, 32'h1234_5678, 5'd0);
    issue("R3 vendor after write", 12'hF11, 3'd2, 32'd0, 5'd0);
    issue("R3 isa", 12'h301, 3'd5, 32'd0, 5'd9);
    issue("R3 isa after write", 12'h301, 3'd2, 32'd0, 5'd0);
    // R8: unmapped numbers
    issue("R8 unmapped write", 12'h123, 3'd1, 32'hCAFE_F00D, 5'd0);
    issue("R8 unmapped read", 12'h123, 3'd2, 32'd0, 5'd0);
    issue("R8 unmapped 7C0", 12'h7C0, 3'd6, 32'd0, 5'd31);
    for (int i = 0; i < 8; i++) issue("R8 others intact", RW_LIST[i], 3'd2, 32'd0, 5'd0);
    // R4: counter, including wrap and write attempts
    issue("R4 cycle", 12'hC00, 3'd2, 32'd0, 5'd0);
    issue("R4 cycle write", 12'hC00, 3'd1, 32'h0000_0000, 5'd0);
    repeat (200) @(negedge clk);
    issue("R4 cycle after idle", 12'hC00, 3'd7, 32'd0, 5'd31);
    repeat (130) @(negedge clk);
    issue("R4 cycle across wrap", 12'hC00, 3'd2, 32'd0, 5'd0);
    // R10: stalled consumer, traffic continues
    stall_en = 1;
    for (int k = 0; k < 40; k++) begin
      issue("R10 stalled write", RW_LIST[k % 8], 3'(1 + (k % 3)), 32'h9E37_79B9 * (k + 1), 5'(k));
      issue("R10 stalled read", RW_LIST[(k + 3) % 8], 3'd2, 32'd0, 5'd0);
      if (k % 10 == 0) issue("R4 cycle under stall", 12'hC00, 3'd2, 32'd0, 5'd0);
    end
    stall_en = 0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule